// File: doc/BRIEF.md
# Mode supervisor with window watchdog

This block sequences a device through four operating modes: Reset, Normal Request, Normal and Sleep. After a reset interval the device waits in Normal Request. The host must command Normal within a fixed number of millisecond ticks, or the supervisor raises a reset request. Once in Normal, a windowed watchdog runs. A clear that arrives too early, or no clear before the period ends, sends the device back to Reset and records a timeout flag in a small status word.

All timing is counted in ticks from an external millisecond timebase. The watchdog period comes from a parameter. When the configuration pin is reported floating, the watchdog switches to a fallback period and raises an error flag. Two supply faults bypass the normal sequence and send the device to Sleep: a VDD under-voltage seen in Reset without a supply under-voltage, and a VDD over-temperature. Over-temperature first passes through one cycle of Reset. Sleep ends only with the block's reset.

Top module: `modesup_top`

## Requirements
- R1: Mode is encoded Reset=0, Normal Request=1, Normal=2, Sleep=3. While the reset input is low, the block shows mode 0, a high reset request and a status word of 0 apart from bit 2.
- R2: Reset mode lasts RST_HOLD tick cycles and then moves to Normal Request.
- R3: In Normal Request, a mode command moves to Normal on the next clock. Without a command, the block returns to Reset after NREQ_TIMEOUT tick cycles. Watchdog clears have no effect in this mode.
- R4: The timers advance only in cycles where the tick input is high.
- R5: In Normal, a clear during the closed window goes to Reset on the next clock and sets status bit 3. The closed window is the first P/2 ticks of the period P.
- R6: In Normal, a clear during the open window (counts P/2 to P-1) keeps the mode at Normal and restarts the period from zero.
- R7: In Normal, P tick cycles without a clear lead to Reset and set status bit 3.
- R8: Status bit 3 stays set through Reset and Normal Request. It is cleared when Normal is next entered.
- R9: Status bit 2 follows the floating-configuration input. While that input is high, P is FALLBACK_PERIOD instead of WD_PERIOD.
- R10: In Reset, VDD under-voltage with no supply under-voltage moves to Sleep on the next clock. With supply under-voltage also present, Reset proceeds normally.
- R11: VDD over-temperature in Normal Request or Normal moves to Reset on the next clock and then to Sleep on the following clock.
- R12: Sleep persists until the reset input, whatever the ticks, commands and clears. The reset request is low in Sleep.
- R13: The reset request output is high exactly while the mode is Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle millisecond timebase pulse |
| wd_clear | input | 1 | Watchdog clear strobe |
| go_normal | input | 1 | Command strobe requesting Normal mode |
| cfg_float | input | 1 | Watchdog configuration pin reported floating |
| vdd_uv | input | 1 | VDD under-voltage level |
| vdd_ot | input | 1 | VDD over-temperature level |
| sup_uv | input | 1 | Supply under-voltage level |
| mode | output | 2 | Current mode (R1 encoding) |
| rst_req | output | 1 | Reset request to the rest of the device |
| wd_status | output | 4 | Bit 3 timeout flag, bit 2 config error, bits 1:0 zero |

## Verification
A wrong count in the shared tick counter appears at the ports as a mode change one or more tick cycles early or late. So the bench measures every Reset, Normal Request and watchdog interval to the exact cycle. A misplaced window boundary turns a clear at one specific count into a reset, or fails to do so. The bench therefore sweeps the clear over every count of the period, for both the configured period and the fallback period, and sees the result one clock after the clear. A lost fault flag or a lost over-temperature memory shows up within two clocks as a wrong status bit, or as a Reset that does not fall into Sleep.

// File: rtl/modesup_pkg.sv
package modesup_pkg;
  typedef enum logic [1:0] {
    MS_RESET  = 2'd0,
    MS_NREQ   = 2'd1,
    MS_NORMAL = 2'd2,
    MS_SLEEP  = 2'd3
  } ms_mode_e;

  function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/modesup_rst_sync.sv
module modesup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/modesup_tick_counter.sv
module modesup_tick_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)      cnt_n = '0;
    else if (inc) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/modesup_wd_window.sv
module modesup_wd_window #(
  parameter int unsigned CW        = 8,
  parameter int unsigned WD_PERIOD = 100,
  parameter int unsigned FALLBACK  = 150
) (
  input  logic          cfg_float,
  input  logic [CW-1:0] cnt,
  output logic          period_last,
  output logic          window_closed
);
  localparam logic [CW-1:0] NOM_LAST = CW'(WD_PERIOD - 1);
  localparam logic [CW-1:0] NOM_HALF = CW'(WD_PERIOD / 2);
  localparam logic [CW-1:0] FB_LAST  = CW'(FALLBACK - 1);
  localparam logic [CW-1:0] FB_HALF  = CW'(FALLBACK / 2);

  generate
    if (WD_PERIOD == FALLBACK) begin : g_single
      logic unused_cfg;
      assign unused_cfg    = cfg_float;
      assign period_last   = (cnt == NOM_LAST);
      assign window_closed = (cnt < NOM_HALF);
    end else begin : g_dual
      assign period_last   = cfg_float ? (cnt == FB_LAST) : (cnt == NOM_LAST);
      assign window_closed = cfg_float ? (cnt < FB_HALF)  : (cnt < NOM_HALF);
    end
  endgenerate
endmodule

// File: rtl/modesup_fsm.sv
module modesup_fsm
  import modesup_pkg::*;
#(
  parameter int unsigned CW           = 8,
  parameter int unsigned RST_HOLD     = 8,
  parameter int unsigned NREQ_TIMEOUT = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wd_clear,
  input  logic          go_normal,
  input  logic          vdd_uv,
  input  logic          vdd_ot,
  input  logic          sup_uv,
  input  logic [CW-1:0] cnt,
  input  logic          period_last,
  input  logic          window_closed,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output ms_mode_e      state,
  output logic          to_flag
);
  localparam logic [CW-1:0] HOLD_LAST = CW'(RST_HOLD - 1);
  localparam logic [CW-1:0] NREQ_LAST = CW'(NREQ_TIMEOUT - 1);

  ms_mode_e state_q, state_n;
  logic     ot_pend_q, ot_pend_n;
  logic     flag_q, flag_n;
  logic     restart;

  always_comb begin
    state_n   = state_q;
    ot_pend_n = ot_pend_q;
    flag_n    = flag_q;
    restart   = 1'b0;
    unique case (state_q)
      MS_RESET: begin
        if (ot_pend_q || vdd_ot || (vdd_uv && !sup_uv)) state_n = MS_SLEEP;
        else if (tick && (cnt == HOLD_LAST))             state_n = MS_NREQ;
      end
      MS_NREQ: begin
        if (vdd_ot) begin
          state_n   = MS_RESET;
          ot_pend_n = 1'b1;
        end else if (go_normal) begin
          state_n = MS_NORMAL;
          flag_n  = 1'b0;
        end else if (tick && (cnt == NREQ_LAST)) begin
          state_n = MS_RESET;
        end
      end
      MS_NORMAL: begin
        if (vdd_ot) begin
          state_n   = MS_RESET;
          ot_pend_n = 1'b1;
        end else if (wd_clear) begin
          if (window_closed) begin
            state_n = MS_RESET;
            flag_n  = 1'b1;
          end else begin
            restart = 1'b1;
          end
        end else if (tick && period_last) begin
          state_n = MS_RESET;
          flag_n  = 1'b1;
        end
      end
      default: begin
        state_n = MS_SLEEP;
      end
    endcase
  end

  assign cnt_clr = (state_n != state_q) || restart;
  assign cnt_inc = tick && (state_q != MS_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= MS_RESET;
      ot_pend_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      state_q   <= state_n;
      ot_pend_q <= ot_pend_n;
      flag_q    <= flag_n;
    end
  end

  assign state   = state_q;
  assign to_flag = flag_q;
endmodule

// File: rtl/modesup_top.sv
module modesup_top
  import modesup_pkg::*;
#(
  parameter int unsigned RST_HOLD     = 8,
  parameter int unsigned NREQ_TIMEOUT = 150,
  parameter int unsigned WD_PERIOD    = 100,
  parameter int unsigned FALLBACK     = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wd_clear,
  input  logic       go_normal,
  input  logic       cfg_float,
  input  logic       vdd_uv,
  input  logic       vdd_ot,
  input  logic       sup_uv,
  output logic [1:0] mode,
  output logic       rst_req,
  output logic [3:0] wd_status
);
  localparam int unsigned MAXV = max_of3(RST_HOLD, NREQ_TIMEOUT, max_of3(WD_PERIOD, FALLBACK, 1));
  localparam int unsigned CW   = $clog2(MAXV + 1);

  logic          rst_s;
  logic          cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;
  logic          period_last, window_closed;
  ms_mode_e      state;
  logic          to_flag;

  modesup_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  modesup_tick_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .cnt   (cnt)
  );

  modesup_wd_window #(.CW(CW), .WD_PERIOD(WD_PERIOD), .FALLBACK(FALLBACK)) u_win (
    .cfg_float     (cfg_float),
    .cnt           (cnt),
    .period_last   (period_last),
    .window_closed (window_closed)
  );

  modesup_fsm #(.CW(CW), .RST_HOLD(RST_HOLD), .NREQ_TIMEOUT(NREQ_TIMEOUT)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_s),
    .tick          (tick),
    .wd_clear      (wd_clear),
    .go_normal     (go_normal),
    .vdd_uv        (vdd_uv),
    .vdd_ot        (vdd_ot),
    .sup_uv        (sup_uv),
    .cnt           (cnt),
    .period_last   (period_last),
    .window_closed (window_closed),
    .cnt_clr       (cnt_clr),
    .cnt_inc       (cnt_inc),
    .state         (state),
    .to_flag       (to_flag)
  );

  assign mode      = state;
  assign rst_req   = (state == MS_RESET);
  assign wd_status = {to_flag, cfg_float, 2'b00};
endmodule

// File: rtl/modesup_chk.sv
module modesup_chk
  import modesup_pkg::*;
(
  input logic       clk,
  input logic       rst_s,
  input logic [1:0] mode,
  input logic [3:0] wd_status,
  input logic       go_normal,
  input logic       vdd_ot,
  input logic       vdd_uv,
  input logic       sup_uv
);
  a_r3_cmd_enters_normal: assert property (@(posedge clk) disable iff (!rst_s)
    (mode == MS_NREQ && go_normal && !vdd_ot) |=> (mode == MS_NORMAL));

  a_r11_ot_to_reset: assert property (@(posedge clk) disable iff (!rst_s)
    ((mode == MS_NORMAL || mode == MS_NREQ) && vdd_ot) |=> (mode == MS_RESET));

  a_r10_uv_to_sleep: assert property (@(posedge clk) disable iff (!rst_s)
    (mode == MS_RESET && vdd_uv && !sup_uv) |=> (mode == MS_SLEEP));

  a_r12_sleep_holds: assert property (@(posedge clk) disable iff (!rst_s)
    (mode == MS_SLEEP) |=> (mode == MS_SLEEP));

  a_r8_flag_clear_in_normal: assert property (@(posedge clk) disable iff (!rst_s)
    (mode == MS_NORMAL) |-> !wd_status[3]);

  a_r5_flag_rises_in_reset: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(wd_status[3]) |-> (mode == MS_RESET));

  a_r2_reset_exits: assert property (@(posedge clk) disable iff (!rst_s)
    (mode == MS_RESET) |=> (mode != MS_NORMAL));

  a_r6_normal_exits: assert property (@(posedge clk) disable iff (!rst_s)
    (mode == MS_NORMAL) |=> (mode == MS_NORMAL || mode == MS_RESET));
endmodule

bind modesup_top modesup_chk u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .mode      (mode),
  .wd_status (wd_status),
  .go_normal (go_normal),
  .vdd_ot    (vdd_ot),
  .vdd_uv    (vdd_uv),
  .sup_uv    (sup_uv)
);

// File: tb/sim_modesup_top.sv
module sim_modesup_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;
  localparam int NRQ  = 10;
  localparam int WDP  = 8;
  localparam int FBP  = 12;
  localparam int M_RST = 0, M_NRQ = 1, M_NRM = 2, M_SLP = 3;

  logic clk = 1'b0;
  logic rst_n, tick, wd_clear, go_normal, cfg_float, vdd_uv, vdd_ot, sup_uv;
  logic [1:0] mode;
  logic       rst_req;
  logic [3:0] wd_status;
  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modesup_top #(.RST_HOLD(HOLD), .NREQ_TIMEOUT(NRQ), .WD_PERIOD(WDP), .FALLBACK(FBP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wd_clear(wd_clear), .go_normal(go_normal),
    .cfg_float(cfg_float), .vdd_uv(vdd_uv), .vdd_ot(vdd_ot), .sup_uv(sup_uv),
    .mode(mode), .rst_req(rst_req), .wd_status(wd_status));

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic until_change(output int n);
    logic [1:0] m0;
    m0 = mode;
    n = 0;
    while (mode == m0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; wd_clear = 1'b0; go_normal = 1'b0;
    vdd_uv = 1'b0; vdd_ot = 1'b0; sup_uv = 1'b0;
    cyc(3);
    chk("R1 mode in reset", mode, M_RST);
    chk("R13 rst_req in reset", rst_req, 1);
    chk("R1 status in reset", wd_status, cfg_float ? 4 : 0);
    rst_n = 1'b1;
    cyc(4);
    tick = 1'b1;
  endtask

  task automatic to_normal();
    go_normal = 1'b1;
    cyc(1);
    go_normal = 1'b0;
    chk("R3 command enters Normal", mode, M_NRM);
    chk("R8 flag cleared in Normal", wd_status[3], 0);
  endtask

  task automatic reach_nreq();
    int n;
    until_change(n);
    chk("R2 reset hold ticks", n, HOLD);
    chk("R2 mode after hold", mode, M_NRQ);
    chk("R13 rst_req low in NReq", rst_req, 0);
  endtask

  initial begin
    int n;
    int p;
    cfg_float = 1'b0;
    do_reset();
    reach_nreq();

    // R4: no ticks, no progress
    tick = 1'b0;
    cyc(3 * NRQ);
    chk("R4 held without tick", mode, M_NRQ);
    tick = 1'b1;
    // R3: clears ignored in NReq, timeout after NRQ ticks
    wd_clear = 1'b1;
    until_change(n);
    wd_clear = 1'b0;
    chk("R3 NReq timeout ticks", n, NRQ);
    chk("R3 mode after timeout", mode, M_RST);
    chk("R8 no flag on NReq timeout", wd_status[3], 0);

    // R10: supply UV also present -> Reset proceeds
    vdd_uv = 1'b1; sup_uv = 1'b1;
    cyc(1);
    chk("R10 stays Reset with sup_uv", mode, M_RST);
    sup_uv = 1'b0;
    cyc(1);
    chk("R10 Reset to Sleep", mode, M_SLP);
    vdd_uv = 1'b0;
    // R12
    go_normal = 1'b1; wd_clear = 1'b1;
    cyc(40);
    go_normal = 1'b0; wd_clear = 1'b0;
    chk("R12 Sleep persists", mode, M_SLP);
    chk("R12 rst_req low in Sleep", rst_req, 0);

    // R5 R6 R7 R9: sweep clear position over both periods
    for (int cf = 0; cf < 2; cf++) begin
      cfg_float = cf[0];
      p = cf ? FBP : WDP;
      do_reset();
      reach_nreq();
      for (int c = 0; c < p; c++) begin
        to_normal();
        chk("R9 config error bit", wd_status[2], cf);
        cyc(c);
        wd_clear = 1'b1;
        cyc(1);
        wd_clear = 1'b0;
        if (c < p / 2) begin
          chk("R5 closed clear resets", mode, M_RST);
          chk("R5 closed clear flag", wd_status[3], 1);
        end else begin
          chk("R6 open clear keeps Normal", mode, M_NRM);
          until_change(n);
          chk("R7 period after restart", n, p);
          chk("R7 timeout resets", mode, M_RST);
          chk("R7 timeout flag", wd_status[3], 1);
        end
        until_change(n);
        chk("R2 hold after watchdog reset", n, HOLD);
        chk("R8 flag kept in NReq", wd_status[3], 1);
      end
    end

    // R11: over-temperature in Normal
    cfg_float = 1'b0;
    do_reset();
    reach_nreq();
    to_normal();
    vdd_ot = 1'b1;
    cyc(1);
    vdd_ot = 1'b0;
    chk("R11 OT Normal to Reset", mode, M_RST);
    chk("R13 rst_req with OT", rst_req, 1);
    cyc(1);
    chk("R11 OT Reset to Sleep", mode, M_SLP);

    // R11: over-temperature in NReq
    do_reset();
    reach_nreq();
    vdd_ot = 1'b1;
    cyc(1);
    vdd_ot = 1'b0;
    chk("R11 OT NReq to Reset", mode, M_RST);
    cyc(1);
    chk("R11 OT NReq then Sleep", mode, M_SLP);
    cyc(20);
    chk("R12 Sleep after OT", mode, M_SLP);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule